// File: doc/BRIEF.md
# SDRAM Write Auto-Precharge Tracker

This block sits on the controller side of an SDRAM interface. It watches a decoded command bus (a valid strobe, a command type, a bank address and the auto-precharge flag carried on address line 10) and keeps a state per bank: idle, open, writing with auto-precharge, or recovering before the bank may be activated again. The write data phase is shared by all banks, so a single sequencer follows the write burst in flight. It reports which beat the data bus carries in each cycle.

The controller reads a per-bank ready flag to decide when an activate may be issued. The block also checks the command stream. A command aimed at a bank in the middle of an auto-precharge write, an activate to a bank that is not ready, and a read or write to a bank that is not open are each reported with their own violation code. Such a command is dropped and does not change any state. A legal read or write to another bank cuts the current burst short. The recovery of the interrupted bank is then counted from the last beat that was actually written. Burst length and the recovery time in cycles are run-time inputs.

Top module: `wap_tracker`

## Requirements
- R1: After reset every bank is idle, every ready flag is high, no data phase is shown and no violation is reported.
- R2: A command with code 1 (activate) to a ready bank opens it, and its ready flag drops on the next cycle. Code 4 (precharge) to an open bank returns it to idle and ready.
- R3: A command with code 3 (write) and the auto-precharge flag low leaves the bank open after the burst. Its ready flag stays low until a precharge.
- R4: A write with the auto-precharge flag high keeps that bank's ready flag low for exactly t_dal_i cycles after the clock edge that captures the last beat. With t_dal_i of 0 the flag rises on the cycle after that edge.
- R5: The data-phase strobe is high in the cycle a legal write is presented, with beat 0. Beats 1 to burst_len_i-1 then follow on consecutive cycles, for any burst_len_i from 1 upward (2, 4 and 8 included). Outside a burst the strobe is low and the beat output is 0.
- R6: A legal write or a legal read (code 2) arriving during a burst ends that burst in the same cycle. A write puts its own beat 0 in that cycle and a read leaves the data phase low. An interrupted auto-precharge bank becomes ready t_dal_i cycles after the last beat it actually wrote.
- R7: Any non-NOP command to a bank that is running a write with auto-precharge reports violation code 1. The command is dropped and the burst runs on.
- R8: An activate to a bank whose ready flag is low reports violation code 2 and is dropped.
- R9: A read or write to a bank that is not open, and not running an auto-precharge write, reports violation code 3 and is dropped.
- R10: viol_o is high for exactly the one cycle after an offending command, and viol_code_o carries its code in that cycle. In every other cycle both are 0. Code 0 (NOP) and an invalid strobe never raise a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command type: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge |
| bank_i | input | BANK_W | Target bank |
| ap_i | input | 1 | Auto-precharge flag (address line 10) |
| burst_len_i | input | BL_W | Write burst length in beats |
| t_dal_i | input | DAL_W | Data-in to activate delay in cycles |
| ready_o | output | NUM_BANKS | Bank may be activated |
| data_phase_o | output | 1 | Write beat on the data bus this cycle |
| beat_o | output | BL_W | Index of that beat |
| viol_o | output | 1 | Protocol violation seen on the previous cycle |
| viol_code_o | output | 2 | 1 auto-precharge bank hit, 2 activate while not ready, 3 access to closed bank |

## Verification
On every cycle the assertions check four things. An activate to an idle bank opens it. The recovery counter steps down by one while it waits. Each beat is followed by the next unless a read or write cuts in, and an interruption stops the sequencer. A command hitting an auto-precharge bank is flagged on the next cycle. The exact cycle on which a ready flag rises after a full burst, after an interrupted burst and with a zero delay can only be shown by the bench's scenarios. The same holds for a dropped command leaving no trace and for a read interrupt leaving the data bus empty. The bench's reference model predicts these and compares all outputs on every clock.

// File: rtl/wap_pkg.sv
package wap_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE     = 2'd0,
    BK_OPEN     = 2'd1,
    BK_AP_BURST = 2'd2,
    BK_AP_WAIT  = 2'd3
  } bank_st_e;

  typedef enum logic [1:0] {
    V_NONE     = 2'd0,
    V_AP_SAME  = 2'd1,
    V_ACT_BUSY = 2'd2,
    V_NOT_OPEN = 2'd3
  } viol_e;
endpackage

// File: rtl/wap_cmd_check.sv
module wap_cmd_check
  import wap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                      cmd_valid_i,
  input  cmd_e                      cmd_i,
  input  logic [BANK_W-1:0]         bank_i,
  input  logic [NUM_BANKS-1:0][1:0] st_i,
  output logic [NUM_BANKS-1:0]      act_o,
  output logic [NUM_BANKS-1:0]      pre_o,
  output logic                      wr_o,
  output logic                      rdwr_o,
  output viol_e                     code_o
);
  bank_st_e tgt_st;
  logic     acc;

  always_comb begin
    tgt_st = bank_st_e'(st_i[bank_i]);
    acc    = 1'b0;
    code_o = V_NONE;
    if (cmd_valid_i && cmd_i != CMD_NOP) begin
      if (tgt_st == BK_AP_BURST) begin
        code_o = V_AP_SAME;
      end else begin
        case (cmd_i)
          CMD_ACT: if (tgt_st == BK_IDLE) acc = 1'b1; else code_o = V_ACT_BUSY;
          CMD_RD,
          CMD_WR:  if (tgt_st == BK_OPEN) acc = 1'b1; else code_o = V_NOT_OPEN;
          CMD_PRE: acc = 1'b1;
          default: acc = 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      act_o[b] = acc && cmd_i == CMD_ACT && bank_i == BANK_W'(b);
      pre_o[b] = acc && cmd_i == CMD_PRE && bank_i == BANK_W'(b);
    end
  end

  assign wr_o   = acc && cmd_i == CMD_WR;
  assign rdwr_o = acc && (cmd_i == CMD_WR || cmd_i == CMD_RD);
endmodule

// File: rtl/wap_burst_seq.sv
module wap_burst_seq #(
  parameter int BANK_W = 2,
  parameter int BL_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic              rdwr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  input  logic [BL_W-1:0]   burst_len_i,
  output logic              data_phase_o,
  output logic [BL_W-1:0]   beat_o,
  output logic              end_o,
  output logic [BANK_W-1:0] end_bank_o,
  output logic              end_ap_o,
  output logic              intr_o,
  output logic [BANK_W-1:0] intr_bank_o,
  output logic              intr_ap_o
);
  logic              active_q;
  logic [BL_W-1:0]   beat_q;
  logic [BANK_W-1:0] bank_q;
  logic              ap_q;
  logic [BL_W-1:0]   last;

  assign last = (burst_len_i == '0) ? '0 : burst_len_i - 1'b1;

  // first beat rides on the write command cycle
  assign data_phase_o = wr_start_i || (active_q && !rdwr_i);
  assign beat_o       = (data_phase_o && !wr_start_i) ? beat_q : '0;
  assign end_o        = data_phase_o && beat_o == last;
  assign end_bank_o   = wr_start_i ? bank_i : bank_q;
  assign end_ap_o     = wr_start_i ? ap_i : ap_q;
  assign intr_o       = active_q && rdwr_i;
  assign intr_bank_o  = bank_q;
  assign intr_ap_o    = ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      bank_q   <= '0;
      ap_q     <= 1'b0;
    end else if (wr_start_i) begin
      active_q <= last != '0;
      beat_q   <= BL_W'(1);
      bank_q   <= bank_i;
      ap_q     <= ap_i;
    end else if (rdwr_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (beat_q == last) active_q <= 1'b0;
      else                beat_q   <= beat_q + 1'b1;
    end
  end

  assert_beat_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_phase_o && beat_o != last && $stable(burst_len_i)) |=>
      (rdwr_i || (data_phase_o && beat_o == $past(beat_o) + 1'b1)));

  assert_intr_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && rdwr_i && !wr_start_i) |=> !active_q);
endmodule

// File: rtl/wap_bank_fsm.sv
module wap_bank_fsm
  import wap_pkg::*;
#(
  parameter int DAL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             wr_ap_i,
  input  logic             end_i,
  input  logic             intr_i,
  input  logic [DAL_W-1:0] t_dal_i,
  output logic [1:0]       st_o,
  output logic             ready_o
);
  bank_st_e         st_q, st_d;
  logic [DAL_W-1:0] cnt_q, cnt_d;
  logic [DAL_W-1:0] dal_m1;

  // interrupt is seen one edge after the last written beat
  assign dal_m1 = (t_dal_i == '0) ? '0 : t_dal_i - 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      BK_IDLE: if (act_i) st_d = BK_OPEN;
      BK_OPEN: begin
        if (pre_i) st_d = BK_IDLE;
        else if (wr_ap_i) begin
          if (end_i) begin
            st_d  = (t_dal_i == '0) ? BK_IDLE : BK_AP_WAIT;
            cnt_d = t_dal_i;
          end else begin
            st_d = BK_AP_BURST;
          end
        end
      end
      BK_AP_BURST: begin
        if (end_i) begin
          st_d  = (t_dal_i == '0) ? BK_IDLE : BK_AP_WAIT;
          cnt_d = t_dal_i;
        end else if (intr_i) begin
          st_d  = (dal_m1 == '0) ? BK_IDLE : BK_AP_WAIT;
          cnt_d = dal_m1;
        end
      end
      BK_AP_WAIT: begin
        if (cnt_q <= DAL_W'(1)) st_d = BK_IDLE;
        else                    cnt_d = cnt_q - 1'b1;
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o    = st_q;
  assign ready_o = st_q == BK_IDLE;

  assert_act_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BK_IDLE && act_i) |=> (st_q == BK_OPEN && !ready_o));

  assert_dal_countdown_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BK_AP_WAIT && cnt_q > DAL_W'(1)) |=>
      (st_q == BK_AP_WAIT && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wap_tracker.sv
module wap_tracker
  import wap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BL_W      = 4,
  parameter int DAL_W     = 5,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 ap_i,
  input  logic [BL_W-1:0]      burst_len_i,
  input  logic [DAL_W-1:0]     t_dal_i,
  output logic [NUM_BANKS-1:0] ready_o,
  output logic                 data_phase_o,
  output logic [BL_W-1:0]      beat_o,
  output logic                 viol_o,
  output logic [1:0]           viol_code_o
);
  logic [NUM_BANKS-1:0][1:0] bank_st;
  logic [NUM_BANKS-1:0]      act, pre;
  logic                      wr_acc, rdwr_acc;
  viol_e                     code;
  logic                      end_ev, end_ap, intr_ev, intr_ap;
  logic [BANK_W-1:0]         end_bank, intr_bank;
  logic                      viol_q;
  logic [1:0]                code_q;

  wap_cmd_check #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_check (
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_e'(cmd_i)),
    .bank_i      (bank_i),
    .st_i        (bank_st),
    .act_o       (act),
    .pre_o       (pre),
    .wr_o        (wr_acc),
    .rdwr_o      (rdwr_acc),
    .code_o      (code)
  );

  wap_burst_seq #(.BANK_W(BANK_W), .BL_W(BL_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_start_i   (wr_acc),
    .rdwr_i       (rdwr_acc),
    .bank_i       (bank_i),
    .ap_i         (ap_i),
    .burst_len_i  (burst_len_i),
    .data_phase_o (data_phase_o),
    .beat_o       (beat_o),
    .end_o        (end_ev),
    .end_bank_o   (end_bank),
    .end_ap_o     (end_ap),
    .intr_o       (intr_ev),
    .intr_bank_o  (intr_bank),
    .intr_ap_o    (intr_ap)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wap_bank_fsm #(.DAL_W(DAL_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act[b]),
      .pre_i   (pre[b]),
      .wr_ap_i (wr_acc && ap_i && bank_i == BANK_W'(b)),
      .end_i   (end_ev && end_ap && end_bank == BANK_W'(b)),
      .intr_i  (intr_ev && intr_ap && intr_bank == BANK_W'(b)),
      .t_dal_i (t_dal_i),
      .st_o    (bank_st[b]),
      .ready_o (ready_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      code_q <= 2'd0;
    end else begin
      viol_q <= code != V_NONE;
      code_q <= code;
    end
  end

  assign viol_o      = viol_q;
  assign viol_code_o = code_q;

  assert_ap_hit_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i != 3'd0 && bank_st[bank_i] == BK_AP_BURST) |=>
      (viol_o && viol_code_o == 2'd1));
endmodule

// File: tb/wap_tracker_bench.sv
module wap_tracker_bench;
  localparam int NB = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_i = 3'd0;
  logic [1:0]    bank_i = 2'd0;
  logic          ap_i = 1'b0;
  logic [3:0]    burst_len_i = 4'd4;
  logic [4:0]    t_dal_i = 5'd3;
  logic [NB-1:0] ready_o;
  logic          data_phase_o;
  logic [3:0]    beat_o;
  logic          viol_o;
  logic [1:0]    viol_code_o;

  int checks = 0;
  int fails  = 0;

  // reference model: 0 idle, 1 open, 2 ap burst, 3 ap recovery
  int mst[NB];
  int mcnt[NB];
  bit mact;
  int mbeat, mbank;
  bit map;
  bit mviol;
  int mcode;

  always #10 clk_i = ~clk_i;

  wap_tracker u_wap_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .bank_i(bank_i), .ap_i(ap_i), .burst_len_i(burst_len_i), .t_dal_i(t_dal_i),
    .ready_o(ready_o), .data_phase_o(data_phase_o), .beat_o(beat_o),
    .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NB; k++) begin mst[k] = 0; mcnt[k] = 0; end
    mact = 0; mbeat = 0; mbank = 0; map = 0; mviol = 0; mcode = 0;
  endtask

  task automatic load(input int k, input int n);
    if (n <= 0) mst[k] = 0;
    else begin mst[k] = 3; mcnt[k] = n; end
  endtask

  task automatic step(input int c, input int b, input bit a, input string tag);
    int code, last, ebeat, eb, ib;
    bit acc, wrs, rdwr, edp, eap, iap, endv, intv;
    cmd_valid_i = (c != 0);
    cmd_i = 3'(c); bank_i = 2'(b); ap_i = a;
    #2;
    last = (burst_len_i == 0) ? 0 : int'(burst_len_i) - 1;
    code = 0; acc = 0;
    if (c != 0) begin
      if (mst[b] == 2) code = 1;
      else if (c == 1) begin if (mst[b] == 0) acc = 1; else code = 2; end
      else if (c == 2 || c == 3) begin if (mst[b] == 1) acc = 1; else code = 3; end
      else if (c == 4) acc = 1;
    end
    wrs  = acc && c == 3;
    rdwr = acc && (c == 2 || c == 3);
    edp  = wrs || (mact && !rdwr);
    ebeat = (edp && !wrs) ? mbeat : 0;
    for (int k = 0; k < NB; k++)
      check(ready_o[k] == (mst[k] == 0), tag, $sformatf("ready[%0d]", k),
            int'(ready_o[k]), int'(mst[k] == 0));
    check(data_phase_o == edp, tag, "data_phase", int'(data_phase_o), int'(edp));
    check(int'(beat_o) == ebeat, tag, "beat", int'(beat_o), ebeat);
    check(viol_o == mviol, tag, "viol", int'(viol_o), int'(mviol));
    check(int'(viol_code_o) == mcode, tag, "viol_code", int'(viol_code_o), mcode);
    // advance model to the next edge
    endv = edp && ebeat == last;
    eb   = wrs ? b : mbank;
    eap  = wrs ? a : map;
    intv = mact && rdwr;
    ib   = mbank; iap = map;
    for (int k = 0; k < NB; k++)
      if (mst[k] == 3) begin
        if (mcnt[k] <= 1) mst[k] = 0; else mcnt[k]--;
      end
    if (intv && iap && mst[ib] == 2) load(ib, int'(t_dal_i) - 1);
    if (acc && c == 1) mst[b] = 1;
    if (acc && c == 4 && mst[b] == 1) mst[b] = 0;
    if (wrs && a) mst[b] = 2;
    if (endv && eap && mst[eb] == 2) load(eb, int'(t_dal_i));
    if (wrs) begin
      mact = (last != 0); mbeat = 1; mbank = b; map = a;
    end else if (rdwr) mact = 0;
    else if (mact) begin
      if (mbeat == last) mact = 0; else mbeat++;
    end
    mviol = (code != 0); mcode = code;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: state right after reset
    idle(2, "R1");

    // R2: open and close
    step(1, 0, 0, "R2"); idle(2, "R2");
    step(4, 0, 0, "R2"); idle(1, "R2");

    // R3: write without auto-precharge keeps bank open
    step(1, 1, 0, "R3"); step(3, 1, 0, "R3"); idle(6, "R3");
    step(4, 1, 0, "R3"); idle(1, "R3");

    // R4: full burst with auto-precharge, delay 3
    step(1, 0, 0, "R4"); step(3, 0, 1, "R4"); idle(8, "R4");
    // R4: zero delay, burst of 2
    burst_len_i = 4'd2; t_dal_i = 5'd0;
    step(1, 2, 0, "R4"); step(3, 2, 1, "R4"); idle(3, "R4");

    // R5: burst lengths 2, 8, 1
    t_dal_i = 5'd2;
    step(1, 1, 0, "R5"); step(3, 1, 0, "R5"); idle(3, "R5");
    burst_len_i = 4'd8;
    step(3, 1, 0, "R5"); idle(9, "R5");
    burst_len_i = 4'd1;
    step(3, 1, 1, "R5"); idle(4, "R5");

    // R6: write interrupts an auto-precharge burst on another bank
    burst_len_i = 4'd4; t_dal_i = 5'd3;
    step(1, 0, 0, "R6"); step(1, 1, 0, "R6");
    step(3, 0, 1, "R6"); idle(1, "R6"); step(3, 1, 0, "R6"); idle(7, "R6");
    // R6: read interrupt leaves the data bus empty, delay 1
    t_dal_i = 5'd1;
    step(1, 0, 0, "R6"); step(3, 0, 1, "R6"); step(2, 1, 0, "R6"); idle(4, "R6");
    step(4, 1, 0, "R6"); idle(1, "R6");

    // R7: commands to the bank under auto-precharge write
    t_dal_i = 5'd4;
    step(1, 2, 0, "R7"); step(3, 2, 1, "R7");
    step(3, 2, 0, "R7 R10"); step(2, 2, 0, "R7"); step(4, 2, 0, "R7");
    idle(8, "R7");

    // R8: activate while not ready
    step(1, 3, 0, "R8"); step(1, 3, 0, "R8 R10"); idle(1, "R8");
    step(3, 3, 1, "R8"); idle(4, "R8"); step(1, 3, 0, "R8"); idle(5, "R8");
    step(1, 3, 0, "R8"); idle(1, "R8");

    // R9: access to a closed bank
    step(2, 0, 0, "R9"); step(3, 0, 1, "R9 R10"); idle(2, "R9");
    step(2, 3, 0, "R9"); idle(1, "R9");

    // R10: NOP and invalid strobe are quiet
    cmd_valid_i = 1'b0; cmd_i = 3'd1; bank_i = 2'd3;
    @(posedge clk_i); @(negedge clk_i);
    step(0, 3, 1, "R10"); idle(2, "R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule